// File: doc/BRIEF.md
# Bus Transition Leakage Estimator

This block watches a parallel data bus and, for each word presented with a valid strobe, scores the move from the bus's previous value to the new word under several leakage figures. The figures are the population count of the new word, the number of toggled bits, separate counts of bits that rise and bits that fall, a signed distance in which a rising bit counts +1 and a falling bit counts −1, and a weighted switching figure. In the weighted figure a rising bit is worth 1.0 and a falling bit is worth (1 − d). The discount d is a programmable unsigned fixed-point coefficient.

The previous value can come from three places. It can be the last accepted data word, which is zero for the first word after reset. It can be a bus precharged to all zeroes. It can be a precharge value supplied from outside, which models a randomly precharged bus. Every figure appears on registered outputs one cycle after the strobe, together with an output valid flag.

Top module: `bus_leak_meter`

## Requirements
- R1: `hw_out` is the number of ones in the accepted word.
- R2: `hd_out` is the number of ones in (previous XOR new), and it equals `rise_out + fall_out`.
- R3: `rise_out` counts bits that are 0 in the previous value and 1 in the new word. `fall_out` counts bits that are 1 in the previous value and 0 in the new word.
- R4: `sdist_out` is two's complement and equals the sum over bits of new(i) − previous(i). Its range is −BUS_W to +BUS_W.
- R5: `delta_in` is unsigned Q2.8, so 256 represents 1.0. `wgt_out` is signed with 8 fraction bits and equals rise·256 + fall·(256 − delta_in). With delta 0 it is hd·256, and with delta 512 it is sdist·256.
- R6: `prech_mode` selects the previous value. 0 selects the last accepted word, and that word is zero for the first word after reset. 1 selects all zeroes, which makes `hd_out` equal `hw_out` and `fall_out` 0. 2 selects `prech_in`. 3 behaves as 0. The remembered word is updated on every accepted word, whatever the mode.
- R7: All outputs are updated on the clock edge that samples `in_valid` high, so they are readable the cycle after the strobe. `out_valid` is `in_valid` delayed by one cycle.
- R8: While `in_valid` is low, the data, precharge and delta inputs are ignored. The metric outputs hold their values, and the remembered word is not changed.
- R9: After reset, `out_valid` and every metric output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | BUS_W | New bus word |
| prech_in | input | BUS_W | External precharge value (mode 2) |
| prech_mode | input | 2 | Previous-value source select |
| delta_in | input | COEF_W | Falling-edge discount, unsigned Q2.8 |
| out_valid | output | 1 | Metrics valid, one cycle after strobe |
| hw_out | output | CNT_W | Weight of new word |
| hd_out | output | CNT_W | Toggled bit count |
| rise_out | output | CNT_W | Rising bit count |
| fall_out | output | CNT_W | Falling bit count |
| sdist_out | output | CNT_W+1 | Signed distance, two's complement |
| wgt_out | output | WGT_W | Weighted switching figure, signed, 8 fraction bits |

## Verification
Assertions check several relations on every cycle. The toggle count splits into rise plus fall. The signed distance matches rise minus fall. The weight of the new word bounds its rising count. The all-zero mode gives no falling bits. A zero discount reduces the weighted figure to the toggle count. The valid flag is delayed by exactly one cycle, and the outputs hold between strobes. Only the bench can show that each figure has the right absolute value and that each mode picks the right previous value, including the remembered word across mode changes and idle cycles. The bench covers these with a full sweep of previous/new word pairs under a varying discount, plus ordered sequences in the other modes.

// File: rtl/bus_leak_pkg.sv
// Package: shared encodings for the bus transition leakage estimator.
// Assumes: a 2-bit previous-value source select at the top level.
package bus_leak_pkg;
    typedef enum logic [1:0] {
        PREV_LAST = 2'd0,   // last accepted word
        PREV_ZERO = 2'd1,   // bus precharged to zero
        PREV_EXT  = 2'd2,   // external precharge value
        PREV_ALT  = 2'd3    // alias of PREV_LAST
    } prev_src_e;
endpackage

// File: rtl/prev_word_select.sv
// Module: prev_word_select
// Holds the last accepted bus word and chooses which value the new word is
// compared against. Assumes in_valid marks accepted words; the history
// register is updated on every accepted word in every mode.
module prev_word_select
    import bus_leak_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_word,
    input  logic [BUS_W-1:0] prech_in,
    input  logic [1:0]       prech_mode,
    output logic [BUS_W-1:0] prev_word
);
    logic [BUS_W-1:0] hist_q;
    prev_src_e        src;

    // Remember the last accepted word; zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (in_valid)
            hist_q <= in_word;
    end

    // Pick the previous-value source.
    always_comb begin
        src = prev_src_e'(prech_mode);
        unique case (src)
            PREV_ZERO: prev_word = '0;
            PREV_EXT:  prev_word = prech_in;
            default:   prev_word = hist_q;
        endcase
    end
endmodule

// File: rtl/transition_counter.sv
// Module: transition_counter
// Purely combinational per-bit transition classifier and counters. Assumes
// CNT_W can hold BUS_W. The toggle count and the signed distance are each
// formed from their own bit terms, not from the rise/fall counts.
module transition_counter #(
    parameter int BUS_W = 8,
    parameter int CNT_W = $clog2(BUS_W + 1)
) (
    input  logic [BUS_W-1:0] prev_word,
    input  logic [BUS_W-1:0] new_word,
    output logic [CNT_W-1:0] hw,
    output logic [CNT_W-1:0] hd,
    output logic [CNT_W-1:0] rise,
    output logic [CNT_W-1:0] fall,
    output logic [CNT_W:0]   sdist
);
    localparam int SD_W = CNT_W + 1;

    logic [BUS_W-1:0] rise_bit;
    logic [BUS_W-1:0] fall_bit;
    logic [BUS_W-1:0] togl_bit;

    // Per-bit transition classes.
    for (genvar i = 0; i < BUS_W; i++) begin : g_bit
        assign rise_bit[i] = new_word[i] & ~prev_word[i];
        assign fall_bit[i] = prev_word[i] & ~new_word[i];
        assign togl_bit[i] = prev_word[i] ^ new_word[i];
    end

    // Population counts and signed per-bit difference sum.
    always_comb begin
        hw    = '0;
        hd    = '0;
        rise  = '0;
        fall  = '0;
        sdist = '0;
        for (int i = 0; i < BUS_W; i++) begin
            hw    = hw   + CNT_W'(new_word[i]);
            hd    = hd   + CNT_W'(togl_bit[i]);
            rise  = rise + CNT_W'(rise_bit[i]);
            fall  = fall + CNT_W'(fall_bit[i]);
            sdist = sdist + SD_W'(new_word[i]) - SD_W'(prev_word[i]);
        end
    end
endmodule

// File: rtl/switch_weight.sv
// Module: switch_weight
// Combinational weighted switching figure: rise*1.0 + fall*(1 - delta).
// Assumes delta is unsigned with FRAC_W fraction bits, COEF_W > FRAC_W,
// and WGT_W wide enough for the most negative value BUS_W*(1 - max delta).
module switch_weight #(
    parameter int CNT_W  = 4,
    parameter int COEF_W = 10,
    parameter int FRAC_W = 8,
    parameter int WGT_W  = CNT_W + COEF_W + 1
) (
    input  logic [CNT_W-1:0]  rise,
    input  logic [CNT_W-1:0]  fall,
    input  logic [COEF_W-1:0] delta,
    output logic [WGT_W-1:0]  weighted
);
    localparam int CW  = COEF_W + 1;
    localparam int ONE = 1 << FRAC_W;

    logic signed [CW-1:0]    fall_coef;
    logic signed [WGT_W-1:0] rise_x;
    logic signed [WGT_W-1:0] fall_x;
    logic signed [WGT_W-1:0] coef_x;
    logic signed [WGT_W-1:0] sum;

    // Falling-edge coefficient (1 - delta) as a signed fixed-point value.
    always_comb fall_coef = $signed(CW'(ONE)) - $signed({1'b0, delta});

    // Weighted sum of the two edge counts.
    always_comb begin
        rise_x   = $signed(WGT_W'(rise));
        fall_x   = $signed(WGT_W'(fall));
        coef_x   = WGT_W'(fall_coef);
        sum      = (rise_x <<< FRAC_W) + fall_x * coef_x;
        weighted = sum;
    end
endmodule

// File: rtl/bus_leak_meter.sv
// Module: bus_leak_meter (top)
// Scores each accepted bus word against the selected previous value and
// registers all leakage figures one cycle after the strobe. Assumes a
// synchronous active-low reset and delta in unsigned Q2.8 by default.
module bus_leak_meter
    import bus_leak_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int COEF_W = 10,
    parameter int FRAC_W = 8,
    localparam int CNT_W = $clog2(BUS_W + 1),
    localparam int WGT_W = CNT_W + COEF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BUS_W-1:0]  in_word,
    input  logic [BUS_W-1:0]  prech_in,
    input  logic [1:0]        prech_mode,
    input  logic [COEF_W-1:0] delta_in,
    output logic              out_valid,
    output logic [CNT_W-1:0]  hw_out,
    output logic [CNT_W-1:0]  hd_out,
    output logic [CNT_W-1:0]  rise_out,
    output logic [CNT_W-1:0]  fall_out,
    output logic [CNT_W:0]    sdist_out,
    output logic [WGT_W-1:0]  wgt_out
);
    logic [BUS_W-1:0] prev_word;
    logic [CNT_W-1:0] hw_c, hd_c, rise_c, fall_c;
    logic [CNT_W:0]   sdist_c;
    logic [WGT_W-1:0] wgt_c;

    prev_word_select #(.BUS_W(BUS_W)) i_prev (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .prech_in   (prech_in),
        .prech_mode (prech_mode),
        .prev_word  (prev_word)
    );

    transition_counter #(.BUS_W(BUS_W), .CNT_W(CNT_W)) i_count (
        .prev_word (prev_word),
        .new_word  (in_word),
        .hw        (hw_c),
        .hd        (hd_c),
        .rise      (rise_c),
        .fall      (fall_c),
        .sdist     (sdist_c)
    );

    switch_weight #(.CNT_W(CNT_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
                    .WGT_W(WGT_W)) i_weight (
        .rise     (rise_c),
        .fall     (fall_c),
        .delta    (delta_in),
        .weighted (wgt_c)
    );

    // Output valid follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Capture metrics on accepted words; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_out    <= '0;
            hd_out    <= '0;
            rise_out  <= '0;
            fall_out  <= '0;
            sdist_out <= '0;
            wgt_out   <= '0;
        end else if (in_valid) begin
            hw_out    <= hw_c;
            hd_out    <= hd_c;
            rise_out  <= rise_c;
            fall_out  <= fall_c;
            sdist_out <= sdist_c;
            wgt_out   <= wgt_c;
        end
    end

    AST_HD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (CNT_W+1)'(hd_out) == (CNT_W+1)'(rise_out) + (CNT_W+1)'(fall_out)); // R2
    AST_SDIST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> $signed(sdist_out) == $signed({1'b0, rise_out}) - $signed({1'b0, fall_out})); // R4
    AST_HW_BOUNDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> hw_out >= rise_out); // R3
    AST_ZERO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && prech_mode == PREV_ZERO) |=> (fall_out == '0 && hd_out == hw_out)); // R6
    AST_WGT_NO_DISCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && delta_in == '0) |=> wgt_out == (WGT_W'(hd_out) << FRAC_W)); // R5
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(hw_out) && $stable(hd_out) && $stable(sdist_out) && $stable(wgt_out))); // R8
endmodule

// File: tb/test_bus_leak_meter.sv
// Bench for bus_leak_meter: reset state, full previous/new sweep in external
// precharge mode, ordered sequences in the other modes, idle-cycle behaviour.
module test_bus_leak_meter;
    localparam int BUS_W  = 8;
    localparam int COEF_W = 10;
    localparam int CNT_W  = 4;
    localparam int WGT_W  = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [BUS_W-1:0]  in_word = '0;
    logic [BUS_W-1:0]  prech_in = '0;
    logic [1:0]        prech_mode = 2'd0;
    logic [COEF_W-1:0] delta_in = '0;
    logic              out_valid;
    logic [CNT_W-1:0]  hw_out, hd_out, rise_out, fall_out;
    logic [CNT_W:0]    sdist_out;
    logic [WGT_W-1:0]  wgt_out;

    int n_chk = 0;
    int n_err = 0;
    int hist  = 0;
    int cyc   = 0;

    bus_leak_meter i_bus_leak_meter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .prech_in(prech_in), .prech_mode(prech_mode), .delta_in(delta_in),
        .out_valid(out_valid), .hw_out(hw_out), .hd_out(hd_out),
        .rise_out(rise_out), .fall_out(fall_out), .sdist_out(sdist_out),
        .wgt_out(wgt_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    // Apply one accepted word, then check every figure the cycle after.
    task automatic apply(input int mode, input int word, input int pre, input int dlt);
        int prev, hw, rise, fall;
        @(negedge clk);
        prech_mode = mode[1:0];
        in_word    = word[BUS_W-1:0];
        prech_in   = pre[BUS_W-1:0];
        delta_in   = dlt[COEF_W-1:0];
        in_valid   = 1'b1;
        prev = (mode == 1) ? 0 : (mode == 2) ? pre : hist;
        hw = 0; rise = 0; fall = 0;
        for (int i = 0; i < BUS_W; i++) begin
            hw   += (word >> i) & 1;
            rise += (((word >> i) & 1) == 1 && ((prev >> i) & 1) == 0) ? 1 : 0;
            fall += (((word >> i) & 1) == 0 && ((prev >> i) & 1) == 1) ? 1 : 0;
        end
        hist = word;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 out_valid", int'(out_valid), 1);
        chk("R1 hw", int'(hw_out), hw);
        chk("R2 hd", int'(hd_out), rise + fall);
        chk("R3 rise", int'(rise_out), rise);
        chk("R3 fall", int'(fall_out), fall);
        chk("R4 sdist", int'($signed(sdist_out)), rise - fall);
        chk("R5 wgt", int'($signed(wgt_out)), rise * 256 + fall * (256 - dlt));
    endtask

    initial begin
        int h_hw, h_sd, h_wg;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 out_valid", int'(out_valid), 0);
        chk("R9 hw", int'(hw_out), 0);
        chk("R9 sdist", int'(sdist_out), 0);
        chk("R9 wgt", int'(wgt_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 idle valid", int'(out_valid), 0);

        // R6: first word after reset compares against zero
        apply(0, 8'hA5, 8'hFF, 100);
        // R6: last-word chain, with mode 3 as alias
        for (int w = 0; w < 256; w++) apply((w % 2 == 0) ? 0 : 3, (w * 37 + 11) & 255, 8'h3C, (w * 13) & 1023);
        // R6: zero precharge sweep
        for (int w = 0; w < 256; w++) apply(1, w, 8'hFF, 700);
        // R5: delta 0 gives hd*256, delta 512 gives sdist*256, 44 is about 0.17
        apply(2, 8'h0F, 8'hF0, 0);
        apply(2, 8'h0F, 8'hF0, 512);
        apply(2, 8'h00, 8'hFF, 44);
        apply(2, 8'h00, 8'hFF, 1023);
        apply(2, 8'hFF, 8'h00, 1023);
        // R6: history tracks words accepted in other modes
        apply(2, 8'h81, 8'h7E, 256);
        apply(0, 8'h18, 8'h00, 256);

        // R8: idle cycles with changing inputs leave outputs and history alone
        h_hw = int'(hw_out); h_sd = int'($signed(sdist_out)); h_wg = int'($signed(wgt_out));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_word = 8'hFF; prech_in = 8'h55; delta_in = 10'd3; prech_mode = 2'd0;
            chk("R8 hold valid", int'(out_valid), 0);
            chk("R8 hold hw", int'(hw_out), h_hw);
            chk("R8 hold sdist", int'($signed(sdist_out)), h_sd);
            chk("R8 hold wgt", int'($signed(wgt_out)), h_wg);
        end
        apply(0, 8'h24, 8'h00, 300);   // R8: previous must still be 8'h18

        // R2..R5: full sweep of previous/new pairs through external precharge
        for (int p = 0; p < 256; p++)
            for (int n = 0; n < 256; n++)
                apply(2, n, p, (p * 5 + n * 3) & 1023);

        finish_run();
    end
endmodule